// File: doc/BRIEF.md
# Interpolating Line Scaler

This block resamples one streaming line of 8-bit pixels to a new length. A line begins with the pixel that carries the start-of-line flag. The block then produces a programmed number of output pixels and marks the last one. A fixed-point position advances by a programmable step for each output pixel. The step has six fractional bits, so a step of 64 means 1:1, smaller steps enlarge the line and larger steps shrink it. The integer part of the position picks the pair of neighbouring input pixels A and B. The 6-bit fractional part is the interpolation phase.

Four modes share the datapath: pass-through, nearest-neighbour duplication, bilinear blending, and blending with weights taken from a 64-entry user table that is indexed by phase. Each colour channel uses its own instance. Mode, step and output length are captured from the configuration inputs when the start pixel is taken. They then stay fixed for the rest of the line.

Top module: `line_scaler`

## Requirements
- R1: After reset, out_valid and out_eol are 0, in_ready is 1 and no line is active.
- R2: A line starts when a pixel with in_sol is accepted, and cfg_mode, cfg_step and cfg_len are sampled on that pixel. While no line is active, pixels without in_sol are accepted and dropped, and they produce no output. Configuration changes during a line have no effect on that line.
- R3: Mode 0 (pass): every accepted pixel of the line appears unchanged on out_pix one cycle after it is accepted, and the step is ignored.
- R4: The effective step S is cfg_step clamped to the range 2..2048. Output k uses A = in[i] and B = in[i+1], where i = floor(k*S/64) and phase p = (k*S) mod 64.
- R5: Mode 1 (duplicate): the output is A when p < 32 and B otherwise.
- R6: Mode 2 (bilinear): the output is ((64-p)*A + p*B + 32) / 64, rounded down. Table contents have no effect in this mode.
- R7: Mode 3 (table): with w = table[p], the output is floor(((64-w)*A + w*B + 32) / 64), clamped to 0..255. When S > 64 (downscaling), the table is bypassed and w = p is used.
- R8: The table holds 64 unsigned 7-bit weights, and entry p resets to p. A write sets entry tbl_addr to tbl_wdata at the clock edge when tbl_we is high. An output emitted in the cycle of the write uses the old weight, and later outputs use the new one.
- R9: A line produces exactly cfg_len outputs, and out_eol is high only with the last one. When cfg_len is 0 the line produces no output. After the last output, pixels are accepted and dropped until the next pixel with in_sol.
- R10: While the current pixel pair is still incomplete, in_ready is 1 and one pixel is taken per cycle. Once the pair is present, in_ready is 0 and one output is computed per cycle, and it appears registered in the following cycle. For an interpolating line fed without gaps, the first output is therefore visible two cycles after the start pixel's edge plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | 0 pass, 1 duplicate, 2 bilinear, 3 table |
| cfg_step | input | STEP_W (12) | Position step per output, 6 fractional bits |
| cfg_len | input | LEN_W (12) | Output pixels per line |
| tbl_we | input | 1 | Weight table write enable |
| tbl_addr | input | 6 | Weight table entry (phase) |
| tbl_wdata | input | 7 | Weight to write |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_sol | input | 1 | Input pixel is the first of a line |
| in_pix | input | 8 | Input pixel value |
| out_valid | output | 1 | Output pixel valid |
| out_eol | output | 1 | Output pixel is the last of the line |
| out_pix | output | 8 | Output pixel value |

## Verification
A table write and an output emission can fall in the same cycle, and both then touch the same table entry. The bench runs a table-mode line with step 16, so the phases cycle through 0, 16, 32 and 48, and the output timing follows R10. It writes entry 16 in exactly the cycle that output 1 (phase 16) is computed. The result is judged by requiring output 1 to carry the old weight and output 5, the next one at phase 16, to carry the new weight.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  localparam int LSC_PIX_W   = 8;
  localparam int LSC_FRAC_W  = 6;
  localparam int LSC_WGT_W   = 7;
  localparam int LSC_UNITY   = 1 << LSC_FRAC_W;
  localparam int LSC_HALF    = LSC_UNITY / 2;
  localparam int LSC_PIX_MAX = (1 << LSC_PIX_W) - 1;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_DUP   = 2'd1,
    MODE_BILIN = 2'd2,
    MODE_TABLE = 2'd3
  } scale_mode_e;

  // Weight given to pixel B for the current phase.
  function automatic logic [LSC_WGT_W-1:0] pick_weight(
    input scale_mode_e               mode,
    input logic                      down,
    input logic [LSC_FRAC_W-1:0]     ph,
    input logic [LSC_WGT_W-1:0]      tw
  );
    logic [LSC_WGT_W-1:0] w;
    case (mode)
      MODE_DUP:   w = (int'(ph) < LSC_HALF) ? '0 : LSC_WGT_W'(LSC_UNITY);
      MODE_TABLE: w = down ? LSC_WGT_W'(ph) : tw;
      default:    w = LSC_WGT_W'(ph);
    endcase
    return w;
  endfunction

  // Two-tap blend with rounding and saturation to the pixel range.
  function automatic logic [LSC_PIX_W-1:0] blend_px(
    input logic [LSC_PIX_W-1:0] a,
    input logic [LSC_PIX_W-1:0] b,
    input logic [LSC_WGT_W-1:0] w
  );
    int wi;
    int acc;
    wi  = int'(w);
    acc = (LSC_UNITY - wi) * int'(a) + wi * int'(b) + LSC_HALF;
    acc = acc >>> LSC_FRAC_W;
    if (acc < 0)
      acc = 0;
    else if (acc > LSC_PIX_MAX)
      acc = LSC_PIX_MAX;
    return LSC_PIX_W'(acc);
  endfunction

endpackage

// File: rtl/lsc_coef_table.sv
module lsc_coef_table
  import lsc_pkg::*;
#(
  parameter int DEPTH = 1 << LSC_FRAC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [LSC_FRAC_W-1:0] waddr,
  input  logic [LSC_WGT_W-1:0]  wdata,
  input  logic [LSC_FRAC_W-1:0] raddr,
  output logic [LSC_WGT_W-1:0]  rdata
);

  logic [DEPTH-1:0][LSC_WGT_W-1:0] flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [LSC_WGT_W-1:0] ent;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent <= LSC_WGT_W'(g);
      else if (we && waddr == LSC_FRAC_W'(g))
        ent <= wdata;
    end
    assign flat[g] = ent;
  end

  assign rdata = flat[raddr];

  // R8: a written weight is readable at the next cycle
  p_tbl_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> flat[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/lsc_step_ctrl.sv
module lsc_step_ctrl
  import lsc_pkg::*;
#(
  parameter int STEP_W   = 12,
  parameter int STEP_MIN = 2,
  parameter int STEP_MAX = 2048,
  parameter int SKIP_W   = STEP_W - LSC_FRAC_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  advance,
  input  logic                  shift,
  input  logic [STEP_W-1:0]     step_in,
  output logic [LSC_FRAC_W-1:0] phase,
  output logic [SKIP_W-1:0]     skip,
  output logic                  down
);

  localparam int SUM_W = STEP_W + 1;

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_lim;
  logic [SUM_W-1:0]  next_pos;

  always_comb begin
    if (int'(step_in) < STEP_MIN)
      step_lim = STEP_W'(STEP_MIN);
    else if (int'(step_in) > STEP_MAX)
      step_lim = STEP_W'(STEP_MAX);
    else
      step_lim = step_in;
  end

  assign next_pos = SUM_W'(phase) + SUM_W'(step_q);
  assign down     = step_q > STEP_W'(LSC_UNITY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= STEP_W'(LSC_UNITY);
      phase  <= '0;
      skip   <= '0;
    end else if (start) begin
      step_q <= step_lim;
      phase  <= '0;
      skip   <= SKIP_W'(1);
    end else if (advance) begin
      phase  <= next_pos[LSC_FRAC_W-1:0];
      skip   <= next_pos[SUM_W-1:LSC_FRAC_W];
    end else if (shift) begin
      skip   <= skip - SKIP_W'(1);
    end
  end

  // R10: a pixel is only shifted in while one is still owed
  p_skip_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !start) |-> skip != '0);

  // R4: the phase moves only when an output is produced or a line starts
  p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !advance) |=> $stable(phase));

  // R10: computing an output and taking a pixel never coincide
  p_adv_shift_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(advance && shift));

endmodule

// File: rtl/lsc_interp.sv
module lsc_interp
  import lsc_pkg::*;
(
  input  scale_mode_e           mode,
  input  logic                  down,
  input  logic [LSC_FRAC_W-1:0] phase,
  input  logic [LSC_PIX_W-1:0]  pix_a,
  input  logic [LSC_PIX_W-1:0]  pix_b,
  input  logic [LSC_WGT_W-1:0]  tbl_w,
  output logic [LSC_WGT_W-1:0]  weight,
  output logic [LSC_PIX_W-1:0]  pix
);

  assign weight = pick_weight(mode, down, phase, tbl_w);
  assign pix    = blend_px(pix_a, pix_b, weight);

endmodule

// File: rtl/line_scaler.sv
module line_scaler
  import lsc_pkg::*;
#(
  parameter int STEP_W   = 12,
  parameter int LEN_W    = 12,
  parameter int STEP_MIN = 2,
  parameter int STEP_MAX = 2048
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_mode,
  input  logic [STEP_W-1:0]     cfg_step,
  input  logic [LEN_W-1:0]      cfg_len,
  input  logic                  tbl_we,
  input  logic [LSC_FRAC_W-1:0] tbl_addr,
  input  logic [LSC_WGT_W-1:0]  tbl_wdata,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_sol,
  input  logic [LSC_PIX_W-1:0]  in_pix,
  output logic                  out_valid,
  output logic                  out_eol,
  output logic [LSC_PIX_W-1:0]  out_pix
);

  localparam int SKIP_W = STEP_W - LSC_FRAC_W + 1;

  logic                  line_on;
  scale_mode_e           mode_q;
  logic [LEN_W-1:0]      len_q;
  logic [LEN_W-1:0]      out_cnt;
  logic [LSC_PIX_W-1:0]  win_a;
  logic [LSC_PIX_W-1:0]  win_b;

  logic [LSC_FRAC_W-1:0] phase;
  logic [SKIP_W-1:0]     skip;
  logic                  down;
  logic [LSC_WGT_W-1:0]  tbl_w;
  logic [LSC_WGT_W-1:0]  weight;
  logic [LSC_PIX_W-1:0]  interp_pix;

  // named internal events
  logic                  accept;
  logic                  sol_take;
  logic                  in_line;
  logic                  emit;
  logic                  pass_fire;
  logic                  fire;
  logic                  last_out;
  logic                  shift;
  scale_mode_e           mode_cur;
  logic [LEN_W-1:0]      len_cur;
  logic [LEN_W-1:0]      cnt_cur;

  assign in_ready  = !line_on || mode_q == MODE_PASS || skip != '0;
  assign accept    = in_valid && in_ready;
  assign sol_take  = accept && in_sol;
  assign in_line   = sol_take || line_on;
  assign mode_cur  = sol_take ? scale_mode_e'(cfg_mode) : mode_q;
  assign len_cur   = sol_take ? cfg_len : len_q;
  assign cnt_cur   = sol_take ? '0 : out_cnt;
  assign emit      = line_on && mode_q != MODE_PASS && skip == '0;
  assign pass_fire = accept && in_line && mode_cur == MODE_PASS && len_cur != '0;
  assign fire      = pass_fire || emit;
  assign last_out  = cnt_cur == len_cur - LEN_W'(1);
  assign shift     = accept && line_on && !sol_take && mode_q != MODE_PASS;

  lsc_step_ctrl #(
    .STEP_W   (STEP_W),
    .STEP_MIN (STEP_MIN),
    .STEP_MAX (STEP_MAX),
    .SKIP_W   (SKIP_W)
  ) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sol_take),
    .advance (emit),
    .shift   (shift),
    .step_in (cfg_step),
    .phase   (phase),
    .skip    (skip),
    .down    (down)
  );

  lsc_coef_table u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .raddr (phase),
    .rdata (tbl_w)
  );

  lsc_interp u_interp (
    .mode   (mode_q),
    .down   (down),
    .phase  (phase),
    .pix_a  (win_a),
    .pix_b  (win_b),
    .tbl_w  (tbl_w),
    .weight (weight),
    .pix    (interp_pix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_on   <= 1'b0;
      mode_q    <= MODE_PASS;
      len_q     <= '0;
      out_cnt   <= '0;
      win_a     <= '0;
      win_b     <= '0;
      out_valid <= 1'b0;
      out_eol   <= 1'b0;
      out_pix   <= '0;
    end else begin
      if (sol_take) begin
        mode_q <= scale_mode_e'(cfg_mode);
        len_q  <= cfg_len;
      end
      if (sol_take || fire)
        out_cnt <= cnt_cur + LEN_W'(fire);
      line_on <= in_line && len_cur != '0 && !(fire && last_out);
      if (accept && in_line && mode_cur != MODE_PASS) begin
        win_a <= win_b;
        win_b <= in_pix;
      end
      out_valid <= fire;
      out_eol   <= fire && last_out;
      if (fire)
        out_pix <= pass_fire ? in_pix : interp_pix;
    end
  end

  // R9: end-of-line only marks a valid pixel
  p_eol_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> out_valid);

  // R9: a running line never has delivered its full length
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_on |-> out_cnt < len_q);

  // R10: input is held off while an output is being computed
  p_ready_emit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> !in_ready);

  // R3: a pass-mode pixel inside a line comes out unchanged next cycle
  p_pass_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_on && mode_q == MODE_PASS && accept && !in_sol)
      |=> (out_valid && out_pix == $past(in_pix)));

  // R5: duplicate mode outputs one of the two window pixels
  p_dup_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && mode_q == MODE_DUP)
      |=> (out_pix == $past(win_a) || out_pix == $past(win_b)));

  // R6: a bilinear result lies between its two source pixels
  p_bilin_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && mode_q == MODE_BILIN)
      |-> ((interp_pix >= win_a && interp_pix <= win_b) ||
           (interp_pix >= win_b && interp_pix <= win_a)));

endmodule

// File: tb/line_scaler_test.sv
module line_scaler_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [11:0] cfg_step = '0;
  logic [11:0] cfg_len = '0;
  logic        tbl_we = 1'b0;
  logic [5:0]  tbl_addr = '0;
  logic [6:0]  tbl_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sol = 1'b0;
  logic [7:0]  in_pix = '0;
  logic        out_valid;
  logic        out_eol;
  logic [7:0]  out_pix;

  int n_chk  = 0;
  int n_fail = 0;
  int tbl_m [64];
  bit done = 1'b0;

  always #5 clk = ~clk;

  line_scaler uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_step(cfg_step), .cfg_len(cfg_len),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_sol(in_sol), .in_pix(in_pix),
    .out_valid(out_valid), .out_eol(out_eol), .out_pix(out_pix)
  );

  // mode[23:22] step[21:10] len[9:2] pattern[1:0]
  localparam logic [23:0] VECS [13] = '{
    {2'd0, 12'd999,  8'd10, 2'd0},
    {2'd1, 12'd24,   8'd30, 2'd2},
    {2'd1, 12'd150,  8'd12, 2'd0},
    {2'd2, 12'd40,   8'd25, 2'd2},
    {2'd2, 12'd64,   8'd16, 2'd0},
    {2'd2, 12'd200,  8'd10, 2'd2},
    {2'd3, 12'd20,   8'd20, 2'd1},
    {2'd2, 12'd0,    8'd40, 2'd0},
    {2'd2, 12'd4000, 8'd4,  2'd2},
    {2'd1, 12'd2048, 8'd3,  2'd0},
    {2'd2, 12'd2,    8'd64, 2'd2},
    {2'd0, 12'd64,   8'd0,  2'd0},
    {2'd2, 12'd40,   8'd0,  2'd1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pix_at(input int pat, input int i);
    case (pat)
      0:       return (i * 37 + 11) % 256;
      1:       return (i % 2 == 1) ? 255 : 0;
      2:       return (i * i * 13 + 91) % 256;
      default: return (i % 2 == 1) ? 10 : 200;
    endcase
  endfunction

  function automatic int mix(input int a, input int b, input int w);
    int t;
    t = a * (64 - w) + b * w + 32;
    if (t < 0) return 0;
    t = t / 64;
    return (t > 255) ? 255 : t;
  endfunction

  task automatic wr_tbl(input int a, input int v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 6'(a); tbl_wdata = 7'(v);
    @(negedge clk);
    tbl_we = 1'b0;
    tbl_m[a] = v;
  endtask

  task automatic run_line(input int mode, input int step, input int len, input int pat,
                          input int wr_it, input int wr_addr, input int wr_val, input int wr_k);
    int s, n_in, idx, it, nout, neol, first_it, tail;
    int expv [64];
    string tag;
    s = (step < 2) ? 2 : ((step > 2048) ? 2048 : step);
    if (mode == 0)      tag = "R3";
    else if (mode == 1) tag = "R4/R5";
    else if (mode == 2) tag = "R4/R6";
    else                tag = "R7/R8";
    n_in = (mode == 0 || len == 0) ? len + 3 : (((len - 1) * s) >> 6) + 5;
    for (int k = 0; k < len; k++) begin
      int pos, i, p, a, b, w;
      pos = k * s; i = pos >> 6; p = pos % 64;
      a = pix_at(pat, i); b = pix_at(pat, i + 1);
      if (mode == 0)      expv[k] = pix_at(pat, k);
      else if (mode == 1) expv[k] = (p < 32) ? a : b;
      else begin
        w = p;
        if (mode == 3 && s <= 64) w = (k >= wr_k && p == wr_addr) ? wr_val : tbl_m[p];
        expv[k] = mix(a, b, w);
      end
    end
    idx = 0; it = 0; nout = 0; neol = 0; first_it = -1; tail = 0;
    while (1) begin
      @(negedge clk);
      if (out_valid) begin
        if (nout == 0) first_it = it;
        if (nout < len) chk(int'(out_pix) == expv[nout], tag, int'(out_pix), expv[nout]);
        if (out_eol) begin
          neol++;
          chk(nout == len - 1, "R9 eol position", nout, len - 1);
        end
        nout++;
      end
      tbl_we = (it == wr_it); tbl_addr = 6'(wr_addr); tbl_wdata = 7'(wr_val);
      if (it == 0) begin
        cfg_mode = 2'(mode); cfg_step = 12'(step); cfg_len = 12'(len);
      end else begin  // R2: later changes must not matter
        cfg_mode = 2'(mode ^ 1); cfg_step = 12'(4095 - step); cfg_len = 12'(len + 9);
      end
      if (idx >= n_in) begin
        in_valid = 1'b0; in_sol = 1'b0;
        tail++;
        if (tail > 4) break;
      end else begin
        in_valid = 1'b1; in_sol = (idx == 0); in_pix = 8'(pix_at(pat, idx));
        if (in_ready) idx++;
      end
      it++;
      if (it > 20000) begin
        chk(1'b0, "line watchdog", it, 0);
        break;
      end
    end
    tbl_we = 1'b0;
    chk(nout == len, "R9 output count", nout, len);
    chk(neol == ((len > 0) ? 1 : 0), "R9 eol count", neol, (len > 0) ? 1 : 0);
    if (len > 0) chk(first_it == ((mode == 0) ? 1 : 3), "R10 first output cycle",
                     first_it, (mode == 0) ? 1 : 3);
  endtask

  initial begin
    for (int p = 0; p < 64; p++) tbl_m[p] = p;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(out_eol == 1'b0, "R1 out_eol", int'(out_eol), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

    // R2: pixels without a start flag are dropped while idle
    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b1; in_sol = 1'b0; in_pix = 8'(i * 50);
      cfg_mode = 2'd0; cfg_len = 12'd8;
      @(negedge clk);
      chk(in_ready == 1'b1, "R2 idle ready", int'(in_ready), 1);
      chk(out_valid == 1'b0, "R2 idle no output", int'(out_valid), 0);
    end
    in_valid = 1'b0;

    // stimulus table
    for (int v = 0; v < 13; v++)
      run_line(int'(VECS[v][23:22]), int'(VECS[v][21:10]), int'(VECS[v][9:2]),
               int'(VECS[v][1:0]), -1, 0, 0, 9999);

    // R7: saturation at both ends with an extreme table
    for (int p = 0; p < 64; p++) wr_tbl(p, 127);
    run_line(3, 16, 12, 3, -1, 0, 0, 9999);
    // R7: downscaling bypasses the table
    run_line(3, 100, 10, 3, -1, 0, 0, 9999);
    // R6: bilinear ignores the table contents
    run_line(2, 40, 10, 3, -1, 0, 0, 9999);
    // R8: restore identity, then write entry 16 in the cycle output 1 is computed
    for (int p = 0; p < 64; p++) wr_tbl(p, p);
    run_line(3, 16, 12, 2, 3, 16, 5, 2);
    tbl_m[16] = 5;
    // R8: the written weight persists into the next line
    run_line(3, 16, 8, 0, -1, 0, 0, 9999);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule